// File: doc/BRIEF.md
# Channel Event Interrupt Controller

This block gathers per-channel frame and line events from a set of receive channels, together with a handful of global error events, into one status word. Each event sets its own status bit. Software clears bits by writing ones to the status word, and the block drives one interrupt line.

The status bits are grouped by event kind. Within each group, the channel index is the offset from the group's base. The five global error bits sit above all the channel groups. Interrupt enables for channel events are taken from each channel's control word, which arrives as an input. Enables for the global errors come from a small mask register that software writes through the same simple register port. Status bits always record their events. The enables act only on the interrupt line.

Top module: `chan_event_irq`

## Requirements
- R1: After reset the status word reads 0, the error mask reads 0 and `irq` is low.
- R2: A frame-start event on channel x sets status bit x. A frame-end event on channel x sets status bit 4+x.
- R3: A frame-end-acknowledge event on channel x sets status bit 8+x. A line-end event sets bit 12+x. A line-end-acknowledge event sets bit 16+x.
- R4: Each global error bit sets one status bit. `err_evt[0]` (FIFO overflow) sets bit 20. `err_evt[1]` (discard on overflow) sets bit 21. `err_evt[2]` (discard on length limit) sets bit 22. `err_evt[3]` (discard, unmatched) sets bit 23. `err_evt[4]` (discard, inactive channel) sets bit 24.
- R5: Status bits latch whether or not the event is enabled, and they stay set until they are cleared.
- R6: A write to offset 0x00 clears every status bit whose data bit is 1 and leaves the other bits untouched. Writing back the value just read therefore leaves the word at 0.
- R7: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: Within the control word of channel x (word x of `ch_ctrl`, 32 bits each), bits 13 to 17 enable frame start, frame end, frame-end acknowledge, line end and line-end acknowledge for that channel. Each enable affects only its own channel's event.
- R9: Bits 4:0 of the error mask at offset 0x20 enable status bits 20 to 24 in order. The mask reads back at 0x20, and its upper bits read as 0.
- R10: `irq` is a register holding the OR of all set and enabled status bits. It rises one cycle after such a bit appears in the status word, and it falls one cycle after the last such bit is cleared or disabled.
- R11: Reads from any offset other than 0x00 and 0x20 return 0. Writes to other offsets change neither the status word nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_evt | input | NCH | Frame-start event pulse per channel |
| fe_evt | input | NCH | Frame-end event pulse per channel |
| fe_ack_evt | input | NCH | Frame-end-acknowledge event pulse per channel |
| le_evt | input | NCH | Line-end event pulse per channel |
| le_ack_evt | input | NCH | Line-end-acknowledge event pulse per channel |
| err_evt | input | 5 | Global error event pulses |
| ch_ctrl | input | NCH*32 | Channel control words, channel x in bits 32x+31:32x |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on `addr`) |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives an event into the same cycle as a clear of its bit. A design that lets the clear win would lose that event and read 0. The bench also raises a channel's event with only a neighbouring channel's enable set. Decoding the enable with the wrong channel or group offset would raise `irq` there. A partial write-one-to-clear must leave the zero-data bits intact, which catches a design that loads the status word with the write data. `irq` is sampled both one and two cycles after an event, so a line driven combinationally, or delayed by an extra stage, would be seen.

// File: rtl/chan_event_irq.sv
module chan_event_irq #(
  parameter int NCH         = 4,
  parameter int CW          = 32,
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int NERR        = 5,
  parameter int EN_LSB      = 13,
  parameter logic [7:0] ADDR_STATUS = 8'h00,
  parameter logic [7:0] ADDR_MASK   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fs_evt,
  input  logic [NCH-1:0]    fe_evt,
  input  logic [NCH-1:0]    fe_ack_evt,
  input  logic [NCH-1:0]    le_evt,
  input  logic [NCH-1:0]    le_ack_evt,
  input  logic [NERR-1:0]   err_evt,
  input  logic [NCH*CW-1:0] ch_ctrl,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);

  localparam int NGRP    = 5;
  localparam int CH_BITS = NGRP * NCH;
  localparam int SW      = CH_BITS + NERR;

  logic [NGRP-1:0][NCH-1:0] ch_evt;
  logic [NGRP-1:0][NCH-1:0] ch_en;
  logic [SW-1:0]   set_vec, en_vec, clr_vec, status_q;
  logic [NERR-1:0] mask_q;
  logic            irq_q;
  logic            wr_status, wr_mask;
  logic            unused_bits;

  assign ch_evt  = {le_ack_evt, le_evt, fe_ack_evt, fe_evt, fs_evt};
  assign set_vec = {err_evt, ch_evt};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar x = 0; x < NCH; x++) begin : g_ch
      assign ch_en[g][x] = ch_ctrl[x*CW + EN_LSB + g];
    end
  end

  assign en_vec    = {mask_q, ch_en};
  assign wr_status = wr_en && (addr == AW'(ADDR_STATUS));
  assign wr_mask   = wr_en && (addr == AW'(ADDR_MASK));
  assign clr_vec   = wr_status ? wdata[SW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (wr_mask) mask_q <= wdata[NERR-1:0];
      irq_q    <= |(status_q & en_vec);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_STATUS))    rdata[SW-1:0]   = status_q;
    else if (addr == AW'(ADDR_MASK)) rdata[NERR-1:0] = mask_q;
  end

  assign irq = irq_q;
  assign unused_bits = ^{wdata, ch_ctrl};

  for (genvar i = 0; i < SW; i++) begin : g_chk
    // R7
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status_q[i]);
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr_vec[i]) |=> status_q[i]);
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_vec) == '0) |=> !irq);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(status_q) != '0));
  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata[NERR-1:0])));

endmodule

// File: tb/chan_event_irq_bench.sv
module chan_event_irq_bench;
  localparam int NCH = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] fs_evt = 0, fe_evt = 0, fe_ack_evt = 0, le_evt = 0, le_ack_evt = 0;
  logic [4:0] err_evt = 0;
  logic [NCH*32-1:0] ch_ctrl = 0;
  logic wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chan_event_irq u_chan_event_irq (
    .clk(clk), .rst_n(rst_n), .fs_evt(fs_evt), .fe_evt(fe_evt),
    .fe_ack_evt(fe_ack_evt), .le_evt(le_evt), .le_ack_evt(le_ack_evt),
    .err_evt(err_evt), .ch_ctrl(ch_ctrl), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic pulse(int grp, int ch);
    case (grp)
      0: fs_evt[ch] = 1;
      1: fe_evt[ch] = 1;
      2: fe_ack_evt[ch] = 1;
      3: le_evt[ch] = 1;
      4: le_ack_evt[ch] = 1;
      default: err_evt[ch] = 1;
    endcase
    @(negedge clk);
    fs_evt = 0; fe_evt = 0; fe_ack_evt = 0; le_evt = 0; le_ack_evt = 0; err_evt = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 status", v, 0);
    rd(8'h20, v); chk("R1 mask", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_groups(int g0, int g1, string tag);
    logic [31:0] v;
    for (int g = g0; g <= g1; g++)
      for (int x = 0; x < NCH; x++) begin
        pulse(g, x);
        rd(8'h00, v); chk(tag, v, 32'd1 << (g*4 + x));
        wr(8'h00, v);
      end
  endtask

  task automatic t_errors();
    logic [31:0] v;
    for (int e = 0; e < 5; e++) begin
      pulse(5, e);
      rd(8'h00, v); chk("R4 error bit", v, 32'd1 << (20 + e));
      wr(8'h00, v);
    end
  endtask

  task automatic t_sticky_w1c();
    logic [31:0] v;
    fs_evt = '1; fe_evt = '1; fe_ack_evt = '1; le_evt = '1; le_ack_evt = '1; err_evt = '1;
    @(negedge clk);
    fs_evt = 0; fe_evt = 0; fe_ack_evt = 0; le_evt = 0; le_ack_evt = 0; err_evt = 0;
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R5 all latched", v, 32'h01FF_FFFF);
    chk("R5 no irq when disabled", irq, 0);
    wr(8'h00, 32'h00AA_AAAA);
    rd(8'h00, v); chk("R6 partial clear", v, 32'h0155_5555);
    wr(8'h00, v);
    rd(8'h00, v); chk("R6 write-back clears", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(1, 3); pulse(0, 1);
    fs_evt[1] = 1; wr_en = 1; addr = 8'h00; wdata = 32'h0000_0082;
    @(negedge clk);
    fs_evt = 0; wr_en = 0; wdata = 0;
    rd(8'h00, v); chk("R7 set beats clear", v, 32'h0000_0002);
    wr(8'h00, v);
  endtask

  task automatic t_chan_enable();
    logic [31:0] v;
    ch_ctrl[1*32 + 15] = 1;
    pulse(2, 0);
    @(negedge clk);
    chk("R8 other channel no irq", irq, 0);
    wr(8'h00, 32'h0000_0100);
    pulse(2, 1);
    chk("R10 irq not yet", irq, 0);
    @(negedge clk);
    chk("R8 enabled irq", irq, 1);
    wr(8'h00, 32'h0000_0200);
    chk("R10 irq holds one cycle", irq, 1);
    @(negedge clk);
    chk("R10 irq falls", irq, 0);
    ch_ctrl = 0;
    rd(8'h00, v); chk("R6 cleared", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R9 mask readback", v, 32'h1F);
    wr(8'h20, 32'h08);
    pulse(5, 2);
    @(negedge clk);
    chk("R9 masked error no irq", irq, 0);
    pulse(5, 3);
    @(negedge clk);
    chk("R9 unmasked error irq", irq, 1);
    wr(8'h00, 32'h01C0_0000);
    @(negedge clk);
    chk("R10 irq after clear", irq, 0);
  endtask

  task automatic t_other();
    logic [31:0] v;
    pulse(0, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R11 other read zero", v, 0);
    rd(8'h00, v); chk("R11 status kept", v, 32'h1);
    rd(8'h20, v); chk("R11 mask kept", v, 32'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_groups(0, 1, "R2 frame bit");
    t_groups(2, 4, "R3 ack/line bit");
    t_errors();
    t_sticky_w1c();
    t_collide();
    t_chan_enable();
    t_mask();
    t_other();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule